// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimation Converter

This block turns the single-bit output of an oversampling sigma-delta modulator into a 15-bit unsigned conversion result. It runs on the modulator's own clock and takes one stream bit on each rising edge. Each conversion counts the ones over a window of modulator cycles. The window length is chosen by a conversion mode, so a longer window trades speed for finer resolution. The ones count is then scaled to the full 15-bit code range by a short sequential divider.

A host starts a conversion by pulling an active-low start line low. When the result is available, a ready flag rises. The result can be read in parallel, or shifted out serially, most significant bit first, under a host-driven shift clock. Start requests that arrive while a conversion is running are ignored.

Top module: `sd_decim`

## Requirements
- R1: For a window of N bits containing k ones (k < N), the result is floor(k·32768/N) as 15-bit offset binary. With no ones the result is 0. With exactly half ones it is 16384 (binary 100000000000000).
- R2: When every bit in the window is one, the result is clamped to 32767 (all fifteen bits set) and never wraps to zero.
- R3: Mode codes 1, 2, 3, 4 and 5 select windows of WIN_M1, WIN_M2, WIN_M3, WIN_M4 and WIN_M5 modulator cycles. Codes 0, 6 and 7 select the mode-1 window. The mode is latched when a conversion starts, so later changes to it have no effect on that conversion.
- R4: A conversion counts the stream bits taken on the N rising edges that follow the start edge. Bits present on the start edge itself, and bits present after the window, are not counted.
- R5: A start occurs on a rising edge where conv_n is sampled low after being sampled high on the previous edge, provided the block is idle or ready. Ready goes low on that same edge.
- R6: Ready rises exactly N+17 rising edges after the start edge.
- R7: While a conversion is running, a new high-to-low transition on conv_n is ignored. Holding conv_n low after a conversion completes does not start another conversion.
- R8: The result output changes only on the edge where ready rises. It holds its previous value throughout a conversion.
- R9: When ready rises, rd_data presents result bit 14. Each rising edge of rd_clk shifts the next lower bit onto rd_data; rd_clk is synchronised, so the shift takes effect on the third clk edge after the rd_clk rise. Once all 15 bits have been shifted out, rd_data is 0.
- R10: While reset is asserted, and after it is released, ready, result and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Sigma-delta stream bit |
| conv_n | input | 1 | Active-low convert start |
| mode | input | 3 | Conversion mode code, 1 to 5 |
| rd_clk | input | 1 | Serial shift clock from the host |
| rd_data | output | 1 | Serial result bit, MSB first |
| ready | output | 1 | High when a result is available |
| result | output | 15 | Parallel conversion result |

## Verification
Counting the start edge as edge 1, ready is due on edge N+18. The bench drives all inputs on falling edges and counts every rising edge from the one that takes conv_n low. It then checks that ready appears first exactly at that count and verifies the result in the same sample. The mid-window check on result is made at the falling edge halfway through the window, where R8 requires the previous value to still be present. Each serial bit is sampled on a falling edge at least four cycles after the preceding rd_clk rise. This spacing allows for the three-edge synchroniser delay before the next bit is compared.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int RES_W = 15;
  localparam logic [RES_W-1:0] RES_MAX = {RES_W{1'b1}};

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_DIV,
    ST_DONE
  } sdd_state_e;
endpackage

// File: rtl/sdd_window_acc.sv
module sdd_window_acc #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] win_len,
  output logic [CNT_W-1:0] ones,
  output logic             last
);
  logic [CNT_W-1:0] pos;

  // final bit of the window is being taken this cycle
  assign last = en && (pos == win_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos  <= '0;
      ones <= '0;
    end else if (en) begin
      pos  <= pos + CNT_W'(1);
      ones <= ones + CNT_W'(bit_in);
    end
  end
endmodule

// File: rtl/sdd_divider.sv
module sdd_divider #(
  parameter int Q_W = 15,
  parameter int D_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [D_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic [Q_W-1:0] quo,
  output logic           done
);
  localparam int K_W = $clog2(Q_W);

  logic [D_W:0]   rem;
  logic [D_W:0]   rem2;
  logic           ge;
  logic [K_W-1:0] step;
  logic           busy;

  // restoring step: numerator is num * 2^Q_W, num < den
  assign rem2 = {rem[D_W-1:0], 1'b0};
  assign ge   = rem2 >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      quo  <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem  <= {1'b0, num};
        step <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        rem <= ge ? (rem2 - {1'b0, den}) : rem2;
        quo <= {quo[Q_W-2:0], ge};
        if (step == K_W'(Q_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + K_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sdd_shift_out.sv
module sdd_shift_out #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         enable,
  input  logic         rd_clk,
  output logic         rd_data
);
  logic [2:0]   sync;
  logic         rise;
  logic [W-1:0] sreg;

  assign rise    = sync[1] && !sync[2];
  assign rd_data = sreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= '0;
      sreg <= '0;
    end else begin
      sync <= {sync[1:0], rd_clk};
      if (load) begin
        sreg <= load_val;
      end else if (enable && rise) begin
        sreg <= {sreg[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sd_decim.sv
module sd_decim
  import sdd_pkg::*;
#(
  parameter int WIN_M1 = 1024,
  parameter int WIN_M2 = 512,
  parameter int WIN_M3 = 192,
  parameter int WIN_M4 = 96,
  parameter int WIN_M5 = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_bit,
  input  logic             conv_n,
  input  logic [2:0]       mode,
  input  logic             rd_clk,
  output logic             rd_data,
  output logic             ready,
  output logic [RES_W-1:0] result
);
  localparam int WMAX12 = (WIN_M1 > WIN_M2) ? WIN_M1 : WIN_M2;
  localparam int WMAX34 = (WIN_M3 > WIN_M4) ? WIN_M3 : WIN_M4;
  localparam int WMAX   = (WMAX12 > WMAX34) ?
                          ((WMAX12 > WIN_M5) ? WMAX12 : WIN_M5) :
                          ((WMAX34 > WIN_M5) ? WMAX34 : WIN_M5);
  localparam int CNT_W  = $clog2(WMAX + 1);

  sdd_state_e       state;
  logic             conv_q;
  logic             start;
  logic [CNT_W-1:0] win_sel;
  logic [CNT_W-1:0] win_q;
  logic [CNT_W-1:0] ones;
  logic             last;
  logic             div_go;
  logic [RES_W-1:0] div_q;
  logic             div_done;
  logic             finish;
  logic [RES_W-1:0] final_val;

  always_comb begin
    case (mode)
      3'd2:    win_sel = CNT_W'(WIN_M2);
      3'd3:    win_sel = CNT_W'(WIN_M3);
      3'd4:    win_sel = CNT_W'(WIN_M4);
      3'd5:    win_sel = CNT_W'(WIN_M5);
      default: win_sel = CNT_W'(WIN_M1);
    endcase
  end

  assign start = conv_q && !conv_n && (state == ST_IDLE || state == ST_DONE);
  assign finish = (state == ST_DIV) && div_done;
  assign final_val = (ones == win_q) ? RES_MAX : div_q;

  sdd_window_acc #(.CNT_W(CNT_W)) acc_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .en      (state == ST_ACC),
    .bit_in  (mod_bit),
    .win_len (win_q),
    .ones    (ones),
    .last    (last)
  );

  sdd_divider #(.Q_W(RES_W), .D_W(CNT_W)) div_i (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (ones),
    .den  (win_q),
    .quo  (div_q),
    .done (div_done)
  );

  sdd_shift_out #(.W(RES_W)) sout_i (
    .clk      (clk),
    .rst      (rst),
    .load     (finish),
    .load_val (final_val),
    .enable   (ready),
    .rd_clk   (rd_clk),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      conv_q <= 1'b1;
      win_q  <= CNT_W'(WIN_M1);
      div_go <= 1'b0;
      ready  <= 1'b0;
      result <= '0;
    end else begin
      conv_q <= conv_n;
      div_go <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_ACC;
            win_q <= win_sel;
            ready <= 1'b0;
          end
        end
        ST_ACC: begin
          if (last) begin
            state  <= ST_DIV;
            div_go <= 1'b1;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            result <= final_val;
            ready  <= 1'b1;
            state  <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker #(
  parameter int WMIN = 48
) (
  input logic        clk,
  input logic        rst,
  input logic        conv_n,
  input logic        ready,
  input logic        rd_data,
  input logic [14:0] result
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || ready) low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(ready) |-> $stable(result));

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> !$past(conv_n));

  // R6
  min_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(low_cnt) >= 16'(WMIN + 16)));

  // R9
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (rd_data == result[14]));
endmodule

bind sd_decim sdd_checker #(
  .WMIN(((WIN_M1 < WIN_M2 ? WIN_M1 : WIN_M2) < (WIN_M3 < WIN_M4 ? WIN_M3 : WIN_M4)) ?
        ((WIN_M1 < WIN_M2 ? WIN_M1 : WIN_M2) < WIN_M5 ? (WIN_M1 < WIN_M2 ? WIN_M1 : WIN_M2) : WIN_M5) :
        ((WIN_M3 < WIN_M4 ? WIN_M3 : WIN_M4) < WIN_M5 ? (WIN_M3 < WIN_M4 ? WIN_M3 : WIN_M4) : WIN_M5))
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .conv_n  (conv_n),
  .ready   (ready),
  .rd_data (rd_data),
  .result  (result)
);

// File: tb/sd_decim_tb_top.sv
module sd_decim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W1 = 40;
  localparam int W2 = 32;
  localparam int W3 = 24;
  localparam int W4 = 12;
  localparam int W5 = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic        conv_n = 1'b1;
  logic [2:0]  mode = 3'd1;
  logic        rd_clk = 1'b0;
  logic        rd_data;
  logic        ready;
  logic [14:0] result;

  int checks = 0;
  int failures = 0;
  int prev_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_decim #(.WIN_M1(W1), .WIN_M2(W2), .WIN_M3(W3), .WIN_M4(W4), .WIN_M5(W5)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .mod_bit (mod_bit),
    .conv_n  (conv_n),
    .mode    (mode),
    .rd_clk  (rd_clk),
    .rd_data (rd_data),
    .ready   (ready),
    .result  (result)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int k, input int n);
    return (k >= n) ? 32767 : (k * 32768) / n;
  endfunction

  // one conversion: k ones at the start of an n-bit window
  task automatic run_conv(input int m, input int n, input int k, input bit ign);
    int edges;
    int exp;
    exp = expect_code(k, n);
    @(negedge clk);
    mode = 3'(m);
    conv_n = 1'b0;
    mod_bit = 1'b1;               // R4: bit on the start edge is not counted
    @(posedge clk);
    edges = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        conv_n = 1'b1;
        mode = 3'((m % 5) + 1);   // R3: mode change after start has no effect
      end
      if (ign && i == 3) conv_n = 1'b0;   // R7: request mid-conversion
      if (i == n / 2) chk("R8 result held mid-window", int'(result), prev_exp);
      mod_bit = (i < k);
      @(posedge clk);
      edges++;
    end
    for (int w = 0; w < 100; w++) begin
      @(negedge clk);
      mod_bit = 1'b1;             // R4: bits after the window are not counted
      if (ready) break;
      @(posedge clk);
      edges++;
    end
    chk("R6 ready latency", edges, n + 18);
    chk("R1 R2 R3 result", int'(result), exp);
    prev_exp = exp;
    if (ign) begin
      int held;
      held = 1;
      for (int w = 0; w < 25; w++) begin
        @(negedge clk);
        if (!ready) held = 0;
      end
      chk("R7 conv_n held low does not restart", held, 1);
      conv_n = 1'b1;
      @(posedge clk);
    end
  endtask

  task automatic read_serial(input int exp);
    for (int b = 14; b >= 0; b--) begin
      chk("R9 serial bit", int'(rd_data), (exp >> b) & 1);
      rd_clk = 1'b1;
      repeat (4) @(negedge clk);
      rd_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R9 zero after last bit", int'(rd_data), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", int'(ready), 0);
    chk("R10 result in reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 rd_data after reset", int'(rd_data), 0);
    chk("R10 ready after reset", int'(ready), 0);

    // exhaustive sweep of ones counts in every mode
    for (int k = 0; k <= W1; k++) run_conv(1, W1, k, 1'b0);
    for (int k = 0; k <= W2; k++) run_conv(2, W2, k, 1'b0);
    for (int k = 0; k <= W3; k++) run_conv(3, W3, k, 1'b0);
    for (int k = 0; k <= W4; k++) run_conv(4, W4, k, 1'b0);
    for (int k = 0; k <= W5; k++) run_conv(5, W5, k, 1'b0);

    // R1 midpoint code
    run_conv(2, W2, W2 / 2, 1'b0);
    chk("R1 half ones gives 16384", int'(result), 16384);

    // R3 out-of-range codes use the mode-1 window
    run_conv(0, W1, 13, 1'b0);
    run_conv(7, W1, 27, 1'b0);
    run_conv(6, W1, W1, 1'b0);

    // R7 start requests ignored while busy
    run_conv(4, W4, 5, 1'b1);
    run_conv(3, W3, 17, 1'b1);

    // R9 serial readout
    run_conv(3, W3, 7, 1'b0);
    read_serial(expect_code(7, W3));
    run_conv(1, W1, W1, 1'b0);
    read_serial(32767);
    run_conv(2, W2, 8, 1'b0);
    read_serial(8192);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule